// File: doc/BRIEF.md
# GPIB Controller Host Register Interface

This block is the processor-facing register bank of a GPIB talker/listener controller. The processor places a 16-bit address on a multiplexed bus and pulses an address-latch strobe. The block keeps that address and selects itself only when it falls in an eight-address window. The low three address bits pick a register. A read strobe and a write strobe reach two separate groups of eight registers, and both groups use the same three-bit codes.

Behind the registers there is a received-byte holder, a byte holder for transmission, two interrupt status registers each with its own enable mask, and several mode bytes. A level interrupt is driven from the enabled status bits. The bus side is modelled by two byte streams that use valid/ready. On the receive stream, the block raises ready only while it is addressed to listen and its received-byte holder is empty. A sender must hold its byte until ready is seen. On the transmit stream, the block holds valid and data steady until ready is seen, and the handshake completes on the first clock edge where both are high.

Top module: `gpib_host_regs`

## Requirements
- R1: After reset, `rdata` is 0 with no read access, `irq` is 0, `tx_valid` is 0, every mask and mode byte is 0, and `rx_ready` follows `listen`.
- R2: When `ale` is high at a clock edge, `ad` is captured. The block is selected only while the captured address lies from 0x1028 to 0x102F inclusive. Outside that window, reads return 0 and writes change nothing.
- R3: A cycle is a read when selected with `rd_n`=0 and `wr_n`=1. It is a write when selected with `wr_n`=0 and `rd_n`=1. Any other combination does nothing, and `rdata` is 0 in every cycle that is not a read.
- R4: The read code is the captured address bits [2:0]. The read codes are: 0 received byte, 1 status one, 2 status two, 3 poll-mode byte, 4 address status, 5 auxiliary-mode byte, 6 primary address, 7 secondary address.
- R5: The write codes are: 0 transmit byte, 1 mask one, 2 mask two, 3 poll-mode byte, 4 address-mode byte, 5 auxiliary-mode byte, 6 address byte, 7 end-of-string byte. For write code 6, data bit 7 = 0 loads bits [6:0] into the primary address and bit 7 = 1 loads them into the secondary address. Read codes 6 and 7 return these 7-bit values with bit 7 at 0.
- R6: `rx_ready` = `listen` AND (receive holder empty). An accepted byte fills the holder and sets status-one bit 0. A read of code 0 returns the byte and empties the holder.
- R7: Writing code 0 while `tx_valid` is 0 raises `tx_valid` on the next cycle with the written byte on `tx_data`. `tx_data` holds until `tx_ready`. A write of code 0 while `tx_valid` is 1 is ignored. A completed handshake drops `tx_valid` and sets status-one bit 1.
- R8: Status-two bit 0 is set when an accepted byte equals the end-of-string byte. Status-two bit 1 is set when `listen` rises.
- R9: A read of a status register returns its value and then clears it. An event that arrives in the same cycle as the read is kept.
- R10: `irq` is high exactly while (status one AND mask one) OR (status two AND mask two) is nonzero.
- R11: Read code 4 returns {address-mode bits [5:0], `tx_valid`, `listen`} with `listen` in bit 0. Codes 3 and 5 return the last poll-mode and auxiliary-mode bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch strobe |
| ad | input | 16 | Multiplexed address bus |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| irq | output | 1 | Level interrupt |
| listen | input | 1 | Device addressed to listen |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte accepted |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit byte taken |

## Verification
Every address from 0x1020 to 0x1037 is written with a value derived from the address and then read back. This tells window edges and code aliasing apart from correct decode, and it also covers the full read map. Stream bytes are sent with `listen` low and high and with the holder full and empty, which shows whether acceptance is gated correctly. Both masks are swept over all low-bit patterns against a pending event to show that the interrupt follows only the enabled bits. A status read that coincides with a transmit completion shows that a same-cycle event is not lost.

// File: rtl/ghr_pkg.sv
package ghr_pkg;
  typedef enum logic [2:0] {
    RS_DIN = 3'd0, RS_ST1 = 3'd1, RS_ST2 = 3'd2, RS_SPS = 3'd3,
    RS_ADS = 3'd4, RS_AUX = 3'd5, RS_AD0 = 3'd6, RS_AD1 = 3'd7
  } rd_sel_e;
  typedef enum logic [2:0] {
    WS_DOUT = 3'd0, WS_MSK1 = 3'd1, WS_MSK2 = 3'd2, WS_SPM = 3'd3,
    WS_ADM = 3'd4, WS_AUX = 3'd5, WS_ADR = 3'd6, WS_EOS = 3'd7
  } wr_sel_e;
endpackage

// File: rtl/ghr_addr_latch.sv
module ghr_addr_latch #(
  parameter int AW = 16,
  parameter int SELW = 3,
  parameter logic [AW-1:0] BASE = 16'h1028
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [AW-1:0]   ad,
  output logic            cs,
  output logic [SELW-1:0] sel
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (ale) addr_q <= ad;
  end

  assign cs  = (addr_q[AW-1:SELW] == BASE[AW-1:SELW]);
  assign sel = addr_q[SELW-1:0];

  // R2
  ale_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (addr_q == $past(ad)));
endmodule

// File: rtl/ghr_status_reg.sv
module ghr_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_clr,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] stat_o,
  output logic         hit_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else if (rd_clr) stat_q <= set_i;
    else stat_q <= stat_q | set_i;
  end

  assign stat_o = stat_q;
  assign hit_o  = |(stat_q & mask_i);

  // R9
  set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_i == '0) |=> (stat_q == '0));
endmodule

// File: rtl/ghr_datapath.sv
module ghr_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         listen,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  output logic         rx_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  input  logic         tx_ready,
  input  logic         wr_dout,
  input  logic [W-1:0] wdata,
  input  logic         rd_din,
  input  logic [W-1:0] eos,
  output logic [W-1:0] din,
  output logic         rx_take,
  output logic         tx_done,
  output logic         eos_hit
);
  logic         full_q, txv_q;
  logic [W-1:0] din_q, dout_q;

  assign rx_ready = listen & ~full_q;
  assign rx_take  = rx_valid & rx_ready;
  assign tx_done  = txv_q & tx_ready;
  assign eos_hit  = rx_take & (rx_data == eos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      din_q  <= '0;
    end else if (rx_take) begin
      full_q <= 1'b1;
      din_q  <= rx_data;
    end else if (rd_din) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txv_q  <= 1'b0;
      dout_q <= '0;
    end else if (txv_q) begin
      if (tx_ready) txv_q <= 1'b0;
    end else if (wr_dout) begin
      txv_q  <= 1'b1;
      dout_q <= wdata;
    end
  end

  assign tx_valid = txv_q;
  assign tx_data  = dout_q;
  assign din      = din_q;

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R6
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd_din) |=> $stable(din));
endmodule

// File: rtl/gpib_host_regs.sv
module gpib_host_regs #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] BASE = 16'h1028
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [AW-1:0] ad,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic          listen,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready
);
  import ghr_pkg::*;
  localparam int SELW = 3;
  localparam int NSTAT = 2;

  logic            cs;
  logic [SELW-1:0] sel;
  logic            rd_act, wr_act;
  rd_sel_e         rsel;
  wr_sel_e         wsel;

  logic [DW-1:0] msk1, msk2, spm, aux, eos;
  logic [DW-3:0] adm;
  logic [DW-2:0] ad0, ad1;
  logic          listen_q;
  logic [DW-1:0] din;
  logic          rx_take, tx_done, eos_hit;

  logic [DW-1:0] st_set [NSTAT];
  logic [DW-1:0] st_msk [NSTAT];
  logic [DW-1:0] st_val [NSTAT];
  logic          st_clr [NSTAT];
  logic [NSTAT-1:0] st_hit;

  ghr_addr_latch #(.AW(AW), .SELW(SELW), .BASE(BASE)) u_alat (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad(ad), .cs(cs), .sel(sel)
  );

  assign rd_act = cs & ~rd_n & wr_n;
  assign wr_act = cs & ~wr_n & rd_n;
  assign rsel   = rd_sel_e'(sel);
  assign wsel   = wr_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msk1 <= '0; msk2 <= '0; spm <= '0; aux <= '0; eos <= '0;
      adm <= '0; ad0 <= '0; ad1 <= '0; listen_q <= 1'b0;
    end else begin
      listen_q <= listen;
      if (wr_act) begin
        unique case (wsel)
          WS_MSK1: msk1 <= wdata;
          WS_MSK2: msk2 <= wdata;
          WS_SPM:  spm  <= wdata;
          WS_ADM:  adm  <= wdata[DW-3:0];
          WS_AUX:  aux  <= wdata;
          WS_ADR:  if (wdata[DW-1]) ad1 <= wdata[DW-2:0];
                   else ad0 <= wdata[DW-2:0];
          WS_EOS:  eos  <= wdata;
          default: ;
        endcase
      end
    end
  end

  ghr_datapath #(.W(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .listen(listen),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .wr_dout(wr_act && wsel == WS_DOUT), .wdata(wdata),
    .rd_din(rd_act && rsel == RS_DIN), .eos(eos), .din(din),
    .rx_take(rx_take), .tx_done(tx_done), .eos_hit(eos_hit)
  );

  assign st_set[0] = {{(DW-2){1'b0}}, tx_done, rx_take};
  assign st_set[1] = {{(DW-2){1'b0}}, listen & ~listen_q, eos_hit};
  assign st_msk[0] = msk1;
  assign st_msk[1] = msk2;
  assign st_clr[0] = rd_act && rsel == RS_ST1;
  assign st_clr[1] = rd_act && rsel == RS_ST2;

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    ghr_status_reg #(.W(DW)) u_st (
      .clk(clk), .rst_n(rst_n), .set_i(st_set[g]), .rd_clr(st_clr[g]),
      .mask_i(st_msk[g]), .stat_o(st_val[g]), .hit_o(st_hit[g])
    );
  end

  assign irq = |st_hit;

  always_comb begin
    rdata = '0;
    if (rd_act) begin
      unique case (rsel)
        RS_DIN: rdata = din;
        RS_ST1: rdata = st_val[0];
        RS_ST2: rdata = st_val[1];
        RS_SPS: rdata = spm;
        RS_ADS: rdata = {adm, tx_valid, listen};
        RS_AUX: rdata = aux;
        RS_AD0: rdata = {1'b0, ad0};
        RS_AD1: rdata = {1'b0, ad1};
        default: rdata = '0;
      endcase
    end
  end

  // R3
  rdata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> (!rd_n && wr_n));
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk1 == '0 && msk2 == '0) |-> !irq);
endmodule

// File: tb/tb_gpib_host_regs.sv
`timescale 1ns/1ps
module tb_gpib_host_regs;
  logic        clk = 1'b0, rst_n = 1'b0, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] ad = '0;
  logic [7:0]  wdata = '0, rdata, rx_data = '0, tx_data;
  logic        irq, listen = 1'b0, rx_valid = 1'b0, rx_ready, tx_valid, tx_ready = 1'b0;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  gpib_host_regs dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad(ad), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .rdata(rdata), .irq(irq), .listen(listen),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [15:0] a);
    @(negedge clk); ale = 1'b1; ad = a;
    @(negedge clk); ale = 1'b0;
  endtask

  task automatic wcyc(input logic [7:0] v);
    @(negedge clk); wdata = v; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic rcyc(output logic [7:0] v);
    @(negedge clk); rd_n = 1'b0; #1 v = rdata;
    @(negedge clk); rd_n = 1'b1;
  endtask

  task automatic wreg(input logic [15:0] a, input logic [7:0] v);
    latch(a); wcyc(v);
  endtask

  task automatic rreg(input logic [15:0] a, output logic [7:0] v);
    latch(a); rcyc(v);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v, exp0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R1 rx_ready", {7'b0, rx_ready}, {7'b0, listen});
    rreg(16'h102C, v);
    chk("R1 adm reset", v, 8'h00);

    // R2 window sweep with R4/R5 read map
    tx_ready = 1'b1;
    exp0 = 8'h00;
    for (int a = 16'h1020; a <= 16'h1037; a++) begin
      wreg(a[15:0], {1'b0, a[6:0]});
      if (a >= 16'h1028 && a <= 16'h102F && a[2:0] == 3'd6) exp0 = {1'b0, a[6:0]};
    end
    for (int a = 16'h1020; a <= 16'h1037; a++) begin
      if (a < 16'h1028 || a > 16'h102F) begin
        rreg(a[15:0], v);
        chk("R2 outside read", v, 8'h00);
      end
    end
    rreg(16'h102E, v); chk("R2 R5 primary addr", v, exp0);
    rreg(16'h102F, v); chk("R4 secondary addr", v, 8'h00);
    rreg(16'h102B, v); chk("R4 R11 poll mode", v, 8'h2B);
    rreg(16'h102D, v); chk("R4 R11 aux mode", v, 8'h2D);
    rreg(16'h102C, v); chk("R11 addr status", v, 8'hB0);
    rreg(16'h1029, v); chk("R7 tx done flag", v, 8'h02);
    rreg(16'h1029, v); chk("R9 cleared", v, 8'h00);
    wreg(16'h1029, 8'h00); wreg(16'h102A, 8'h00);

    // R5 secondary address
    wreg(16'h102E, 8'h95);
    rreg(16'h102F, v); chk("R5 secondary", v, 8'h15);
    rreg(16'h102E, v); chk("R5 primary kept", v, exp0);

    // R11
    wreg(16'h102B, 8'hA5); rreg(16'h102B, v); chk("R11 poll", v, 8'hA5);
    wreg(16'h102C, 8'h2B); rreg(16'h102C, v); chk("R11 ads", v, 8'hAC);

    // R3 both strobes low
    latch(16'h102B);
    @(negedge clk); rd_n = 1'b0; wr_n = 1'b0; wdata = 8'h11; #1;
    chk("R3 no read data", rdata, 8'h00);
    @(negedge clk); rd_n = 1'b1; wr_n = 1'b1;
    rcyc(v); chk("R3 no write", v, 8'hA5);

    // R7 transmit
    tx_ready = 1'b0;
    wreg(16'h1028, 8'h55);
    chk("R7 valid", {7'b0, tx_valid}, 8'h01);
    chk("R7 data", tx_data, 8'h55);
    wcyc(8'h66);
    chk("R7 ignored write", tx_data, 8'h55);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R7 drop", {7'b0, tx_valid}, 8'h00);
    rreg(16'h1029, v); chk("R7 flag", v, 8'h02);

    // R9 same-cycle event
    wreg(16'h1028, 8'h77);
    latch(16'h1029);
    @(negedge clk); rd_n = 1'b0; tx_ready = 1'b1; #1 v = rdata;
    chk("R9 read before event", v, 8'h00);
    @(negedge clk); rd_n = 1'b1; tx_ready = 1'b0;
    rcyc(v); chk("R9 event kept", v, 8'h02);

    // R6 receive
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h33;
    @(negedge clk); #1 chk("R6 not listening", {7'b0, rx_ready}, 8'h00);
    rx_valid = 1'b0;
    rreg(16'h1029, v); chk("R6 no event", v, 8'h00);
    listen = 1'b1;
    #1 chk("R6 ready", {7'b0, rx_ready}, 8'h01);
    send(8'h33);
    #1 chk("R6 full", {7'b0, rx_ready}, 8'h00);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h44;
    @(negedge clk); rx_valid = 1'b0;
    rreg(16'h1028, v); chk("R6 byte", v, 8'h33);
    #1 chk("R6 freed", {7'b0, rx_ready}, 8'h01);
    rreg(16'h1029, v); chk("R6 flag", v, 8'h01);
    for (int k = 0; k < 8; k++) begin
      send(8'(k * 17 + 1));
      rreg(16'h1028, v); chk("R6 stream", v, 8'(k * 17 + 1));
    end

    // R8
    wreg(16'h102F, 8'h0A);
    rreg(16'h102A, v); chk("R8 listen rise", v, 8'h02);
    send(8'h0A);
    rreg(16'h1028, v);
    rreg(16'h102A, v); chk("R8 eos match", v, 8'h01);

    // R10 mask sweeps
    rreg(16'h1029, v);
    send(8'h5A);
    for (int m = 0; m < 4; m++) begin
      wreg(16'h1029, 8'(m));
      chk("R10 mask1", {7'b0, irq}, 8'(m & 1));
    end
    rreg(16'h1029, v); chk("R10 status", v, 8'h01);
    #1 chk("R10 irq clear", {7'b0, irq}, 8'h00);
    rreg(16'h1028, v);
    wreg(16'h1029, 8'h00);
    send(8'h0A);
    for (int m = 0; m < 4; m++) begin
      wreg(16'h102A, 8'(m));
      chk("R10 mask2", {7'b0, irq}, 8'(m & 1));
    end
    rreg(16'h102A, v); chk("R10 status2", v, 8'h01);
    #1 chk("R10 irq clear2", {7'b0, irq}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule